// File: doc/BRIEF.md
# Time-Base Watchdog and Interval Timer

This block is the timer unit of a processor core. A free-running 64-bit time base counts one step per cycle in which the `tick` input is high. Software can pick any one of the 64 time-base bits to act as the period of a watchdog and, independently, of a fixed-interval timer. The block turns each rising edge of the chosen bit into a timer event. A decrementer counts down on the same steps. It either reloads itself from a reload register or parks at zero.

All state is reached through a single write port. A 3-bit address selects the register: 0 control, 1 status, 2 decrementer, 3 reload, 4 time-base low word, 5 time-base high word. Every register is also visible as an output for reads.

Watchdog events escalate through two status bits. A further event then takes the action chosen by a write-once reset-control field: a sticky checkstop output or a sticky core reset request. The interrupt request outputs are levels. Each one is its status bit gated by its enable bit.

Top module: `tbase_timer_unit`

## Requirements
- R1: The time base increments by one on each cycle with `tick` high and holds otherwise. A write to address 4 replaces bits 31:0 and a write to address 5 replaces bits 63:32. A write to the time base wins over a step in the same cycle, and a write never produces a timer event.
- R2: The control bit fields are: [5:0] watchdog selector, whose extension [5:2] sits above the low field [1:0]; [7:6] reset control; [13:8] fixed-interval selector, built the same way; [14] watchdog interrupt enable; [15] decrementer interrupt enable; [16] fixed-interval interrupt enable; [17] auto-reload.
- R3: Selector value s watches time-base bit 63-s. Status bit 5 (fixed-interval) sets only when a step makes that bit rise from 0 to 1. A falling edge has no effect.
- R4: On a rising edge of the watchdog bit, the block acts in this order: it sets status bit 0 (enable-next) if that bit is clear; otherwise it sets status bit 1 (watchdog interrupt) if that bit is clear; otherwise it takes the reset-control action.
- R5: The reset-control action copies the reset-control field into status bits [3:2]. Code 01 raises `checkstop`, code 10 raises `core_rst_req`, and codes 00 and 11 raise neither output. Both outputs stay high until reset.
- R6: While the reset-control field is 00, a control write loads any value into it. Once the field is non-zero, writes leave it unchanged until reset.
- R7: Writing a 1 to a status bit clears it and writing a 0 leaves it unchanged. A hardware set in the same cycle wins over the clear.
- R8: `wd_irq`, `dec_irq` and `fit_irq` equal status bits 1, 4 and 5 each ANDed with its enable. A status bit still sets while its enable is 0.
- R9: The decrementer steps down on each tick while it is non-zero. A step from 1 sets status bit 4. With auto-reload on, that step loads the reload value.
- R10: With auto-reload off, the decrementer steps from 1 to 0 and then stays at 0 until it is written.
- R11: After reset, the time base, control, status, decrementer and reload registers and every output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select (0 ctrl, 1 status, 2 dec, 3 reload, 4 tb low, 5 tb high) |
| wr_data | input | 32 | Write data |
| tb_q | output | 64 | Time base |
| ctrl_q | output | 18 | Control register |
| stat_q | output | 6 | Status register |
| dec_q | output | DEC_W | Decrementer |
| rld_q | output | DEC_W | Reload register |
| wd_irq | output | 1 | Watchdog interrupt request |
| dec_irq | output | 1 | Decrementer interrupt request |
| fit_irq | output | 1 | Fixed-interval interrupt request |
| checkstop | output | 1 | Sticky checkstop request |
| core_rst_req | output | 1 | Sticky core reset request |

## Verification
The hardest behaviour to reach from the ports is a rising edge on a high-order time-base bit. Bit 63 would need 2^63 steps to toggle by counting alone. The bench therefore loads the time base so that every bit below the watched one is 1 and the watched bit is 0. A single tick then makes the watched bit rise. Loading all bits up to and including the watched one as 1 makes the next tick produce only a falling edge.

The bench repeats both cases for all 64 selector values of the fixed-interval timer. The watchdog escalation for each reset-control code is driven on the least significant bit, where a rising edge comes every two ticks.

// File: rtl/tbase_timer_unit.sv
module tbase_timer_unit #(
  parameter int DEC_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [2:0]       wr_addr,
  input  logic [31:0]      wr_data,
  output logic [63:0]      tb_q,
  output logic [17:0]      ctrl_q,
  output logic [5:0]       stat_q,
  output logic [DEC_W-1:0] dec_q,
  output logic [DEC_W-1:0] rld_q,
  output logic             wd_irq,
  output logic             dec_irq,
  output logic             fit_irq,
  output logic             checkstop,
  output logic             core_rst_req
);
  localparam int CW = 18;

  logic wr_ctrl, wr_stat, wr_dec, wr_rld, wr_tbl, wr_tbh, tb_wr;
  assign wr_ctrl = wr_en && wr_addr == 3'd0;
  assign wr_stat = wr_en && wr_addr == 3'd1;
  assign wr_dec  = wr_en && wr_addr == 3'd2;
  assign wr_rld  = wr_en && wr_addr == 3'd3;
  assign wr_tbl  = wr_en && wr_addr == 3'd4;
  assign wr_tbh  = wr_en && wr_addr == 3'd5;
  assign tb_wr   = wr_tbl || wr_tbh;

  logic [5:0] wd_sel, fit_sel;
  logic [1:0] rsc;
  logic wd_ie, dec_ie, fit_ie, arl;
  assign wd_sel  = ctrl_q[5:0];
  assign rsc     = ctrl_q[7:6];
  assign fit_sel = ctrl_q[13:8];
  assign wd_ie   = ctrl_q[14];
  assign dec_ie  = ctrl_q[15];
  assign fit_ie  = ctrl_q[16];
  assign arl     = ctrl_q[17];

  // time base and edge detection on the increment itself
  logic [63:0] tb_inc, rise;
  assign tb_inc = tb_q + 64'd1;
  assign rise   = (tick && !tb_wr) ? (tb_inc & ~tb_q) : 64'd0;

  logic wd_hit, fit_hit;
  assign wd_hit  = rise[~wd_sel];
  assign fit_hit = rise[~fit_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tb_q <= '0;
    else if (wr_tbl)  tb_q <= {tb_q[63:32], wr_data};
    else if (wr_tbh)  tb_q <= {wr_data, tb_q[31:0]};
    else if (tick)    tb_q <= tb_inc;
  end

  // control: reset-control field is write-once
  logic [CW-1:0] ctrl_wv;
  always_comb begin
    ctrl_wv = wr_data[CW-1:0];
    if (rsc != 2'b00) ctrl_wv[7:6] = rsc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        ctrl_q <= '0;
    else if (wr_ctrl)  ctrl_q <= ctrl_wv;
  end

  // decrementer
  logic dec_step, dec_hit;
  assign dec_step = tick && !wr_dec && dec_q != '0;
  assign dec_hit  = dec_step && dec_q == DEC_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dec_q <= '0;
      rld_q <= '0;
    end else begin
      if (wr_rld)         rld_q <= DEC_W'(wr_data);
      if (wr_dec)         dec_q <= DEC_W'(wr_data);
      else if (dec_hit)   dec_q <= arl ? rld_q : '0;
      else if (dec_step)  dec_q <= dec_q - DEC_W'(1);
    end
  end

  // watchdog escalation and status
  logic wd_next, wd_int, wd_act;
  assign wd_next = wd_hit && !stat_q[0];
  assign wd_int  = wd_hit && stat_q[0] && !stat_q[1];
  assign wd_act  = wd_hit && stat_q[0] && stat_q[1];

  logic [5:0] stat_n;
  always_comb begin
    stat_n = stat_q & ~(wr_stat ? wr_data[5:0] : 6'd0);
    if (wd_next) stat_n[0] = 1'b1;
    if (wd_int)  stat_n[1] = 1'b1;
    if (wd_act)  stat_n[3:2] = rsc;
    if (dec_hit) stat_n[4] = 1'b1;
    if (fit_hit) stat_n[5] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat_q       <= '0;
      checkstop    <= 1'b0;
      core_rst_req <= 1'b0;
    end else begin
      stat_q <= stat_n;
      if (wd_act && rsc == 2'b01) checkstop    <= 1'b1;
      if (wd_act && rsc == 2'b10) core_rst_req <= 1'b1;
    end
  end

  assign wd_irq  = stat_q[1] && wd_ie;
  assign dec_irq = stat_q[4] && dec_ie;
  assign fit_irq = stat_q[5] && fit_ie;

  a_r1_tb_step: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !tb_wr) |=> tb_q == $past(tb_q) + 64'd1);

  a_r6_rsc_locked: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_q[7:6] != 2'b00) |=> ctrl_q[7:6] == $past(ctrl_q[7:6]));

  a_r4_chk_after_both: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(checkstop) |-> $past(stat_q[1:0]) == 2'b11);

  a_r5_rrq_status: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_rst_req) |-> stat_q[3:2] == 2'b10);

  a_r10_dec_parks: assert property (@(posedge clk) disable iff (!rst_n)
    (dec_q == '0 && !wr_dec) |=> dec_q == '0);

  a_r5_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (checkstop || core_rst_req) |=> (checkstop || core_rst_req));
endmodule

// File: tb/tbase_timer_unit_tb.sv
module tbase_timer_unit_tb;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0;
  logic [2:0] wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [63:0] tb_q;
  logic [17:0] ctrl_q;
  logic [5:0] stat_q;
  logic [31:0] dec_q, rld_q;
  logic wd_irq, dec_irq, fit_irq, checkstop, core_rst_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  tbase_timer_unit #(.DEC_W(32)) u_dut (.*);

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic ticks(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
  endtask

  task automatic wr_tb(input logic [63:0] v);
    wr(3'd4, v[31:0]); wr(3'd5, v[63:32]);
  endtask

  function automatic logic [31:0] mkctrl(input logic [5:0] ws, input logic [1:0] rc,
      input logic [5:0] fs, input logic wie, input logic die, input logic fie, input logic ar);
    return {14'd0, ar, fie, die, wie, fs, rc, ws};
  endfunction

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    // R11 reset state
    check("R11 tb", tb_q, 0);
    check("R11 ctrl", ctrl_q, 0);
    check("R11 stat", stat_q, 0);
    check("R11 dec", dec_q, 0);
    check("R11 outs", {wd_irq, dec_irq, fit_irq, checkstop, core_rst_req}, 0);

    // R1 time base stepping, holding, writing
    ticks(10);
    check("R1 step", tb_q, 10);
    repeat (3) @(negedge clk);
    check("R1 hold", tb_q, 10);
    wr_tb(64'h1234_5678_9abc_def0);
    check("R1 write", tb_q, 64'h1234_5678_9abc_def0);
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd4; wr_data = 32'h5;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R1 write wins", tb_q, 64'h1234_5678_0000_0005);

    // R2/R3 fixed-interval selector sweep: rising vs falling edge
    for (int s = 0; s < 64; s++) begin
      int b;
      b = 63 - s;
      wr(3'd0, mkctrl(6'd0, 2'd0, 6'(s), 1'b0, 1'b0, 1'b1, 1'b0));
      wr_tb((64'd1 << b) - 64'd1);
      wr(3'd1, 32'h3f);
      ticks(1);
      check($sformatf("R3 rise sel %0d", s), {stat_q[5], fit_irq}, 2'b11);
      wr_tb((64'd1 << (b + 1)) - 64'd1);
      wr(3'd1, 32'h3f);
      ticks(1);
      check($sformatf("R3 fall sel %0d", s), stat_q[5], 0);
    end

    // R7 hardware set wins over same-cycle clear
    do_reset();
    wr(3'd0, mkctrl(6'd0, 2'd0, 6'd63, 1'b0, 1'b0, 1'b0, 1'b0));
    @(negedge clk); tick = 1'b1; wr_en = 1'b1; wr_addr = 3'd1; wr_data = 32'h20;
    @(negedge clk); tick = 1'b0; wr_en = 1'b0;
    check("R7 set wins", stat_q[5], 1);
    check("R8 gated fit", fit_irq, 0);

    // R4/R5 watchdog escalation with checkstop code 01
    do_reset();
    wr(3'd0, mkctrl(6'd63, 2'b01, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    ticks(1);
    check("R4 first edge", stat_q, 6'b000001);
    check("R8 no wd irq yet", wd_irq, 0);
    ticks(1);
    check("R4 falling no effect", stat_q, 6'b000001);
    ticks(1);
    check("R4 second edge", stat_q, 6'b000011);
    check("R8 wd irq", wd_irq, 1);
    check("R5 no action yet", checkstop, 0);
    ticks(2);
    check("R5 status copy 01", stat_q, 6'b000111);
    check("R5 checkstop", {checkstop, core_rst_req}, 2'b10);
    wr(3'd0, mkctrl(6'd63, 2'b10, 6'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    check("R6 rsc locked", ctrl_q[7:6], 2'b01);
    wr(3'd1, 32'h0);
    check("R7 zero write", stat_q, 6'b000111);
    wr(3'd1, 32'h2);
    check("R7 w1c", stat_q, 6'b000101);
    check("R8 irq drops", wd_irq, 0);
    check("R5 sticky", checkstop, 1);

    // R5 reset-request code 10 with interrupt disabled
    do_reset();
    wr(3'd0, mkctrl(6'd63, 2'b10, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(5);
    check("R5 status copy 10", stat_q, 6'b001011);
    check("R5 reset req", {checkstop, core_rst_req}, 2'b01);
    check("R8 wd gated", wd_irq, 0);

    // R5 reserved code 11
    do_reset();
    wr(3'd0, mkctrl(6'd63, 2'b11, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(5);
    check("R5 status copy 11", stat_q, 6'b001111);
    check("R5 reserved no action", {checkstop, core_rst_req}, 2'b00);

    // R5/R6 code 00: no action, field still writable
    do_reset();
    wr(3'd0, mkctrl(6'd63, 2'b00, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(5);
    check("R5 code 00 no action", {checkstop, core_rst_req}, 2'b00);
    check("R5 code 00 status", stat_q, 6'b000011);
    wr(3'd0, mkctrl(6'd0, 2'b10, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    check("R6 rsc settable", ctrl_q[7:6], 2'b10);

    // R9 decrementer auto-reload
    do_reset();
    wr(3'd0, mkctrl(6'd0, 2'd0, 6'd0, 1'b0, 1'b1, 1'b0, 1'b1));
    wr(3'd3, 32'd5);
    wr(3'd2, 32'd3);
    check("R9 reload reg", rld_q, 5);
    ticks(1);
    check("R9 step", dec_q, 2);
    check("R9 no event yet", stat_q[4], 0);
    ticks(2);
    check("R9 reloaded", dec_q, 5);
    check("R9 event", {stat_q[4], dec_irq}, 2'b11);
    wr(3'd1, 32'h10);
    check("R8 dec irq drops", dec_irq, 0);

    // R10 no reload: park at zero
    wr(3'd0, mkctrl(6'd0, 2'd0, 6'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    ticks(4);
    check("R10 at one", dec_q, 1);
    ticks(1);
    check("R10 zero", dec_q, 0);
    check("R8 dec gated", {stat_q[4], dec_irq}, 2'b10);
    ticks(3);
    check("R10 stays zero", dec_q, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule